// File: doc/BRIEF.md
# Debug Abstract Command Controller

This block is the abstract-command engine of a debug module. A debugger reaches it through a word-wide debug-bus port. The port carries a valid strobe, a write flag, a 7-bit register address and 32-bit write data, and it returns read data in the same cycle. The block holds these registers:

- a command word
- a control/status word that reports the busy flag and a sticky 3-bit error code
- one data word (data0)
- a small program buffer
- an auto-execute mask

An access-register command moves one word between data0 and a hart general-purpose register over a simple request/acknowledge port. Afterwards it may launch the program buffer and wait for the hart to report done or an exception. The block rejects the access-memory type and any other command type as not supported.

The sequencer has four states:

- **IDLE**: waits for a launch.
- **XFER**: holds the hart register request until it is acknowledged.
- **PB_LAUNCH**: drives a one-cycle execute strobe.
- **PB_WAIT**: waits for done or exception.

It has these transitions:

- IDLE→XFER on a launch with transfer set.
- IDLE→PB_LAUNCH on a launch with only postexec set.
- IDLE→IDLE on a launch with neither flag set; this launch completes at once.
- XFER→PB_LAUNCH on acknowledge with postexec set.
- XFER→IDLE on acknowledge with postexec clear.
- PB_LAUNCH→PB_WAIT unconditionally.
- PB_WAIT→IDLE on done or on exception.

A launch is either a command-word write or an access to a data or program-buffer word whose auto-execute bit is set. An auto-execute launch re-runs the stored command.

Top module: `acmd_ctrl`

## Requirements
- R1: After reset, the control/status word (address 0x16) reads datacount 1 in [3:0], cmderr 0 in [10:8], busy 0 in bit 12 and the program-buffer size in [28:24]. data0 (address 0x04) reads 0.
- R2: A command word (address 0x17) is decoded as follows: type [31:24] = 0, aarsize [22:20] = 2, postincrement in bit 19, postexec in bit 18, transfer in bit 17, write in bit 16, regno in [15:0]. A command with transfer and write set copies data0 into general register regno−0x1000.
- R3: A command with transfer set and write clear copies the addressed general register into data0.
- R4: With postexec set, exec_start pulses for exactly one cycle after any transfer. It never overlaps a hart register request.
- R5: cmderr becomes 2 (not supported), and the hart is not accessed, in these cases:
  - the type is not 0, which includes access memory (type 2);
  - transfer is set and aarsize is not 2;
  - transfer is set and regno lies outside 0x1000 to 0x1000+NUM_GPR−1.
- R6: An exception reported by the hart during program-buffer execution sets cmderr to 3.
- R7: A write to the command, auto-execute, data0 or program-buffer register while busy sets cmderr to 1. The write is dropped.
- R8: A non-zero cmderr is sticky and blocks new commands. Writing ones to bits [10:8] of the control/status word clears the matching bits of cmderr.
- R9: With postincrement set, regno in the stored command (readable at 0x17) increments when the command completes without error. It does not increment after a failed command.
- R10: The auto-execute word (address 0x18) holds a data0 flag in bit 0 and program-buffer flags from bit 16 up. An access to a flagged word (data0 at 0x04, or program-buffer word i at 0x20+i) re-runs the stored command after that access takes effect.
- R11: The busy bit reads 1 from the cycle after a launch until the command completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmi_valid | input | 1 | Debug-bus access strobe |
| dmi_write | input | 1 | 1 = write, 0 = read |
| dmi_addr | input | 7 | Register address |
| dmi_wdata | input | 32 | Write data |
| dmi_rdata | output | 32 | Read data for the addressed register, same cycle |
| hart_req | output | 1 | Hart register access request |
| hart_we | output | 1 | 1 = write hart register |
| hart_regno | output | 16 | Register number of the access |
| hart_wdata | output | 32 | Data written to the hart register |
| hart_rdata | input | 32 | Data read from the hart register |
| hart_ack | input | 1 | Access accepted/complete |
| exec_start | output | 1 | One-cycle strobe that starts program-buffer execution |
| exec_done | input | 1 | Program buffer finished normally |
| exec_exc | input | 1 | Program buffer raised an exception |

## Verification
Most sequencer faults become visible within a few cycles on the busy bit. A state that does not return to IDLE leaves busy stuck, which polling turns into a timeout. A skipped state shows as a missing exec_start or a hart access that never happens, and a follow-up read of a hart register or data0 reveals it at once. Faults in the error logic show in the cmderr field on the next read of the control/status word. Faults in blocking after an error surface as a hart register that changed when it should not have. Faults in postincrement show as a wrong regno in the readback of the command word.

// File: rtl/acmd_pkg.sv
package acmd_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XFER,
        S_PB_LAUNCH,
        S_PB_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BUSY    = 3'd1,
        ERR_NOTSUP  = 3'd2,
        ERR_EXC     = 3'd3,
        ERR_HALTRES = 3'd4,
        ERR_BUS     = 3'd5,
        ERR_OTHER   = 3'd7
    } cmd_err_e;

    localparam logic [6:0] A_DATA0 = 7'h04;
    localparam logic [6:0] A_ACS   = 7'h16;
    localparam logic [6:0] A_CMD   = 7'h17;
    localparam logic [6:0] A_AUTO  = 7'h18;
    localparam logic [6:0] A_PBUF0 = 7'h20;

    localparam logic [7:0] CT_REG = 8'd0;
    localparam logic [2:0] SZ_32  = 3'd2;

    typedef struct packed {
        logic [7:0]  ctype;
        logic        rsvd;
        logic [2:0]  size;
        logic        postinc;
        logic        postexec;
        logic        xfer;
        logic        wr;
        logic [15:0] regno;
    } cmd_word_t;

endpackage

// File: rtl/acmd_decode.sv
module acmd_decode
    import acmd_pkg::*;
#(
    parameter int unsigned NUM_GPR  = 32,
    parameter int unsigned GPR_BASE = 32'h1000
) (
    input  cmd_word_t cmd,
    output logic      ok,
    output cmd_err_e  err
);
    localparam logic [16:0] LO = 17'(GPR_BASE);
    localparam logic [16:0] HI = 17'(GPR_BASE + NUM_GPR);

    logic in_range;

    always_comb begin
        in_range = ({1'b0, cmd.regno} >= LO) && ({1'b0, cmd.regno} < HI);
        ok = 1'b1;
        if (cmd.ctype != CT_REG) begin
            ok = 1'b0;
        end else if (cmd.xfer && ((cmd.size != SZ_32) || !in_range)) begin
            ok = 1'b0;
        end
        err = ok ? ERR_NONE : ERR_NOTSUP;
    end

endmodule

// File: rtl/acmd_seq.sv
module acmd_seq
    import acmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic use_xfer,
    input  logic use_pexec,
    input  logic hart_ack,
    input  logic exec_done,
    input  logic exec_exc,
    output logic busy,
    output logic hart_req,
    output logic exec_start,
    output logic xfer_ack,
    output logic finish,
    output logic exc_hit
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        busy       = 1'b1;
        hart_req   = 1'b0;
        exec_start = 1'b0;
        xfer_ack   = 1'b0;
        finish     = 1'b0;
        exc_hit    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                if (go) begin
                    if (use_xfer)       state_d = S_XFER;
                    else if (use_pexec) state_d = S_PB_LAUNCH;
                    else                finish  = 1'b1;
                end
            end
            S_XFER: begin
                hart_req = 1'b1;
                if (hart_ack) begin
                    xfer_ack = 1'b1;
                    if (use_pexec) begin
                        state_d = S_PB_LAUNCH;
                    end else begin
                        state_d = S_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            S_PB_LAUNCH: begin
                exec_start = 1'b1;
                state_d    = S_PB_WAIT;
            end
            S_PB_WAIT: begin
                if (exec_exc) begin
                    exc_hit = 1'b1;
                    state_d = S_IDLE;
                end else if (exec_done) begin
                    finish  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start); // R4
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        hart_req |-> !exec_start); // R4

endmodule

// File: rtl/acmd_ctrl.sv
module acmd_ctrl
    import acmd_pkg::*;
#(
    parameter int unsigned PB_WORDS = 2,
    parameter int unsigned NUM_GPR  = 32,
    parameter int unsigned GPR_BASE = 32'h1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dmi_valid,
    input  logic        dmi_write,
    input  logic [6:0]  dmi_addr,
    input  logic [31:0] dmi_wdata,
    output logic [31:0] dmi_rdata,
    output logic        hart_req,
    output logic        hart_we,
    output logic [15:0] hart_regno,
    output logic [31:0] hart_wdata,
    input  logic [31:0] hart_rdata,
    input  logic        hart_ack,
    output logic        exec_start,
    input  logic        exec_done,
    input  logic        exec_exc
);
    localparam logic [4:0] PB_SIZE = 5'(PB_WORDS);
    localparam logic [16:0] RLO = 17'(GPR_BASE);
    localparam logic [16:0] RHI = 17'(GPR_BASE + NUM_GPR);

    cmd_word_t            cmd_q, sel_cmd;
    cmd_err_e             cmderr_q, dec_err;
    logic [31:0]          data0_q;
    logic [31:0]          pbuf_q [PB_WORDS];
    logic [PB_WORDS-1:0]  auto_pb_q, pb_hit;
    logic                 auto_d_q;
    logic                 wr, busy, cmd_wr, auto_hit, launch, go, notsup;
    logic                 guarded_wr, busy_viol, dec_ok;
    logic                 xfer_ack, finish, exc_hit, do_inc;

    for (genvar i = 0; i < PB_WORDS; i++) begin : g_pb
        assign pb_hit[i] = dmi_valid && (dmi_addr == A_PBUF0 + 7'(i));
        always_ff @(posedge clk) begin
            if (!rst_n)                           pbuf_q[i] <= '0;
            else if (pb_hit[i] && dmi_write && !busy) pbuf_q[i] <= dmi_wdata;
        end
    end

    assign wr         = dmi_valid && dmi_write;
    assign guarded_wr = wr && ((dmi_addr == A_CMD) || (dmi_addr == A_AUTO) ||
                               (dmi_addr == A_DATA0) || (|pb_hit));
    assign busy_viol  = guarded_wr && busy;
    assign cmd_wr     = wr && (dmi_addr == A_CMD) && !busy && (cmderr_q == ERR_NONE);
    assign auto_hit   = !busy && (cmderr_q == ERR_NONE) &&
                        ((dmi_valid && (dmi_addr == A_DATA0) && auto_d_q) || (|(pb_hit & auto_pb_q)));
    assign launch     = cmd_wr || auto_hit;
    assign sel_cmd    = cmd_wr ? cmd_word_t'(dmi_wdata) : cmd_q;
    assign go         = launch && dec_ok;
    assign notsup     = launch && !dec_ok;
    assign do_inc     = finish && sel_cmd.postinc;

    acmd_decode #(.NUM_GPR(NUM_GPR), .GPR_BASE(GPR_BASE)) u_dec (
        .cmd (sel_cmd),
        .ok  (dec_ok),
        .err (dec_err)
    );

    acmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .use_xfer  (sel_cmd.xfer),
        .use_pexec (sel_cmd.postexec),
        .hart_ack  (hart_ack),
        .exec_done (exec_done),
        .exec_exc  (exec_exc),
        .busy      (busy),
        .hart_req  (hart_req),
        .exec_start(exec_start),
        .xfer_ack  (xfer_ack),
        .finish    (finish),
        .exc_hit   (exc_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            cmderr_q  <= ERR_NONE;
            data0_q   <= '0;
            auto_pb_q <= '0;
            auto_d_q  <= 1'b0;
        end else begin
            if (cmd_wr || do_inc) begin
                cmd_q       <= sel_cmd;
                cmd_q.regno <= sel_cmd.regno + {15'd0, do_inc};
            end
            if (cmderr_q == ERR_NONE) begin
                if (busy_viol)    cmderr_q <= ERR_BUSY;
                else if (notsup)  cmderr_q <= dec_err;
                else if (exc_hit) cmderr_q <= ERR_EXC;
            end else if (wr && (dmi_addr == A_ACS)) begin
                cmderr_q <= cmd_err_e'(cmderr_q & ~dmi_wdata[10:8]);
            end
            if (xfer_ack && !cmd_q.wr)
                data0_q <= hart_rdata;
            else if (wr && (dmi_addr == A_DATA0) && !busy)
                data0_q <= dmi_wdata;
            if (wr && (dmi_addr == A_AUTO) && !busy) begin
                auto_pb_q <= dmi_wdata[16 +: PB_WORDS];
                auto_d_q  <= dmi_wdata[0];
            end
        end
    end

    always_comb begin
        dmi_rdata = '0;
        unique case (dmi_addr)
            A_DATA0: dmi_rdata = data0_q;
            A_ACS:   dmi_rdata = {3'b0, PB_SIZE, 11'b0, busy, 1'b0, cmderr_q, 4'b0, 4'd1};
            A_CMD:   dmi_rdata = cmd_q;
            A_AUTO:  dmi_rdata = {16'(auto_pb_q), 15'b0, auto_d_q};
            default: begin
                for (int i = 0; i < PB_WORDS; i++)
                    if (dmi_addr == A_PBUF0 + 7'(i)) dmi_rdata = pbuf_q[i];
            end
        endcase
    end

    assign hart_we    = cmd_q.wr;
    assign hart_regno = cmd_q.regno;
    assign hart_wdata = data0_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr_q != ERR_NONE && !(wr && dmi_addr == A_ACS)) |=> cmderr_q == $past(cmderr_q)); // R8
    AST_IGNORE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmderr_q != ERR_NONE && !busy) |=> !hart_req); // R8
    AST_REGNO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hart_req |-> ({1'b0, hart_regno} >= RLO && {1'b0, hart_regno} < RHI)); // R5
    AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_hit && cmderr_q == ERR_NONE && !busy_viol) |=> cmderr_q == ERR_EXC); // R6

endmodule

// File: tb/acmd_ctrl_tb.sv
module acmd_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmi_valid = 1'b0, dmi_write = 1'b0;
    logic [6:0]  dmi_addr = '0;
    logic [31:0] dmi_wdata = '0, dmi_rdata;
    logic        hart_req, hart_we, hart_ack, exec_start, exec_done, exec_exc;
    logic [15:0] hart_regno;
    logic [31:0] hart_wdata, hart_rdata;

    int checks = 0, fails = 0, exec_total = 0;
    logic [31:0] hregs [32];
    logic [31:0] model [32];
    logic        ack_q, exc_mode = 1'b0;
    int          ex_cnt;

    always #2 clk = ~clk;

    acmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dmi_valid(dmi_valid), .dmi_write(dmi_write),
        .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata),
        .hart_req(hart_req), .hart_we(hart_we), .hart_regno(hart_regno),
        .hart_wdata(hart_wdata), .hart_rdata(hart_rdata), .hart_ack(hart_ack),
        .exec_start(exec_start), .exec_done(exec_done), .exec_exc(exec_exc)
    );

    function automatic logic [31:0] seed_val(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    function automatic logic [31:0] mk(logic [7:0] t, logic [2:0] sz, logic pinc,
                                       logic pex, logic xf, logic w, logic [15:0] r);
        return {t, 1'b0, sz, pinc, pex, xf, w, r};
    endfunction

    assign hart_ack   = ack_q;
    assign hart_rdata = hregs[hart_regno[4:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            for (int i = 0; i < 32; i++) hregs[i] <= seed_val(i);
        end else begin
            ack_q <= hart_req && !ack_q;
            if (hart_req && ack_q && hart_we) hregs[hart_regno[4:0]] <= hart_wdata;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ex_cnt <= 0; exec_done <= 1'b0; exec_exc <= 1'b0;
        end else begin
            exec_done <= 1'b0; exec_exc <= 1'b0;
            if (exec_start) begin
                ex_cnt <= 5; exec_total <= exec_total + 1;
            end else if (ex_cnt != 0) begin
                ex_cnt <= ex_cnt - 1;
                if (ex_cnt == 1) begin
                    if (exc_mode) exec_exc <= 1'b1;
                    else          exec_done <= 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dmi_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        dmi_valid = 1'b1; dmi_write = 1'b1; dmi_addr = a; dmi_wdata = d;
        @(negedge clk);
        dmi_valid = 1'b0; dmi_write = 1'b0;
    endtask

    task automatic dmi_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        dmi_valid = 1'b1; dmi_write = 1'b0; dmi_addr = a;
        #1 d = dmi_rdata;
        @(negedge clk);
        dmi_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int n = 0; n < 200; n++) begin
            dmi_rd(7'h16, s);
            if (!s[12]) return;
        end
        chk("R11 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic err_code(output logic [31:0] e);
        logic [31:0] s;
        dmi_rd(7'h16, s);
        e = {29'd0, s[10:8]};
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v, e;
        int base;
        void'($urandom(32'd7411));
        for (int i = 0; i < 32; i++) model[i] = seed_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        dmi_rd(7'h16, v); chk("R1 status at reset", v, 32'h0200_0001);
        dmi_rd(7'h04, v); chk("R1 data0 at reset", v, 32'h0);

        dmi_rd(7'h04, v);
        dmi_wr(7'h04, 32'h1234_5678);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1007));
        wait_idle(); model[7] = 32'h1234_5678;
        chk("R2 directed write", hregs[7], 32'h1234_5678);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1001));
        wait_idle(); dmi_rd(7'h04, v);
        chk("R3 directed read", v, model[1]);

        for (int it = 0; it < 40; it++) begin
            int idx;
            idx = int'($urandom % 32);
            if ($urandom % 2) begin
                v = $urandom;
                dmi_wr(7'h04, v);
                dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1000 + 16'(idx)));
                wait_idle(); model[idx] = v;
                chk("R2 random write", hregs[idx], model[idx]);
            end else begin
                dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000 + 16'(idx)));
                wait_idle(); dmi_rd(7'h04, v);
                chk("R3 random read", v, model[idx]);
            end
        end
        err_code(e); chk("R5 no error after legal commands", e, 32'd0);

        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1005));
        wait_idle(); dmi_rd(7'h04, v); chk("R9 read with postinc data", v, model[5]);
        dmi_rd(7'h17, v); chk("R9 regno incremented", {16'd0, v[15:0]}, 32'h1006);

        dmi_wr(7'h04, 32'hCAFE_0001);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 16'h100A));
        wait_idle(); model[10] = 32'hCAFE_0001;
        dmi_wr(7'h18, 32'h0000_0001);
        dmi_wr(7'h04, 32'hCAFE_0002); wait_idle(); model[11] = 32'hCAFE_0002;
        chk("R10 autoexec data first", hregs[11], model[11]);
        dmi_wr(7'h04, 32'hCAFE_0003); wait_idle(); model[12] = 32'hCAFE_0003;
        chk("R10 autoexec data second", hregs[12], model[12]);
        dmi_wr(7'h18, 32'h0);

        base = exec_total;
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0));
        wait_idle();
        dmi_wr(7'h18, 32'h0001_0000);
        dmi_wr(7'h20, 32'h0000_0013); wait_idle();
        chk("R10 autoexec progbuf launches", 32'(exec_total - base), 32'd2);
        dmi_wr(7'h18, 32'h0);
        dmi_rd(7'h20, v); chk("R10 progbuf word stored", v, 32'h0000_0013);

        base = exec_total;
        dmi_wr(7'h04, 32'h0BAD_F00D);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1003));
        dmi_rd(7'h16, v); chk("R11 busy during command", {31'd0, v[12]}, 32'd1);
        wait_idle(); model[3] = 32'h0BAD_F00D;
        chk("R4 transfer before postexec", hregs[3], model[3]);
        chk("R4 one exec launch", 32'(exec_total - base), 32'd1);

        dmi_wr(7'h04, 32'h1111_2222);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0));
        dmi_wr(7'h04, 32'hDEAD_BEEF);
        wait_idle();
        dmi_rd(7'h04, v); chk("R7 write while busy dropped", v, 32'h1111_2222);
        err_code(e); chk("R7 busy error code", e, 32'd1);

        base = exec_total;
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1014));
        repeat (12) @(negedge clk);
        chk("R8 command ignored on error", hregs[20], model[20]);
        chk("R8 no exec on error", 32'(exec_total - base), 32'd0);
        dmi_wr(7'h16, 32'h0000_0700);
        err_code(e); chk("R8 W1C clears", e, 32'd0);

        dmi_wr(7'h04, 32'h5555_AAAA);
        dmi_wr(7'h17, mk(8'd0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1002));
        wait_idle(); err_code(e); chk("R5 bad aarsize", e, 32'd2);
        chk("R5 bad aarsize no access", hregs[2], model[2]);
        dmi_wr(7'h16, 32'h0000_0700);
        dmi_wr(7'h17, mk(8'd2, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1002));
        wait_idle(); err_code(e); chk("R5 access memory type", e, 32'd2);
        dmi_wr(7'h16, 32'h0000_0700);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1020));
        wait_idle(); err_code(e); chk("R5 regno above range", e, 32'd2);
        dmi_wr(7'h16, 32'h0000_0700);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0FFF));
        wait_idle(); err_code(e); chk("R5 regno below range", e, 32'd2);
        dmi_wr(7'h16, 32'h0000_0700);
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h101F));
        wait_idle(); model[31] = 32'h5555_AAAA;
        chk("R2 top register of range", hregs[31], model[31]);

        @(negedge clk); exc_mode = 1'b1;
        dmi_wr(7'h17, mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1004));
        wait_idle(); err_code(e); chk("R6 exception code", e, 32'd3);
        dmi_rd(7'h17, v); chk("R9 no increment on failure", {16'd0, v[15:0]}, 32'h1004);
        @(negedge clk); exc_mode = 1'b0;
        dmi_wr(7'h16, 32'h0000_0100);
        err_code(e); chk("R8 partial W1C", e, 32'd2);
        dmi_wr(7'h16, 32'h0000_0200);
        err_code(e); chk("R8 full clear", e, 32'd0);

        summary();
    end
endmodule